// File: doc/BRIEF.md
# L2 Bucket Slot Search Engine

This block looks up a forwarding key, a 48-bit MAC address paired with a 12-bit filtering ID, in a hashed layer-2 entry table. Each key has two candidate buckets, one from each half of the hash space, and each bucket holds four entries. The engine receives both bucket hashes from outside. It reads the eight candidate entries one at a time through a single read port with one cycle of latency, and it stops at the first entry that either holds the key or is empty.

The result is one of three outcomes: a hit on an existing entry, a free slot where the key can be inserted, or a full condition when every candidate is taken. The outcome comes with the 14-bit table index of the chosen slot. On a hit, the engine also returns the decoded unicast attributes of that entry. Entries flagged as next-hop are reserved for the routing side, so they are never returned, even when they hold the key. A request is one start pulse. The result is valid when done pulses, and it stays on the outputs until the next accepted start.

Top module: `l2_slot_search`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done`, `hit`, `free`, `full`, `mem_rd`, `slot_index` and all entry attribute outputs are zero.
- R2: Candidates are read in ascending order, one read per examined candidate. Candidates 0–3 are read at address {block-0 hash, candidate[1:0]} and candidates 4–7 at {block-1 hash, candidate−4}. The block-0 hash is `bkt_hash[11:0]` and the block-1 hash is `bkt_hash[23:12]`.
- R3: A candidate whose valid bit (word 2 bit 31) is set, whose next-hop bit (word 2 bit 12) is clear, and whose MAC ({word 0, word 1[31:16]}) and FID (word 1[11:0]) both equal the key ends the search with `hit`=1 and `slot_index` set to its address.
- R4: A candidate whose valid bit is clear ends the search with `free`=1 and `slot_index` set to its address, whatever its other bits hold.
- R5: A valid candidate with the next-hop bit set is passed over, even if its MAC and FID equal the key.
- R6: A valid candidate whose MAC or FID differs from the key is passed over.
- R7: When all eight candidates are passed over, the search ends with `full`=1 and `slot_index`=0 after exactly eight reads.
- R8: `done` is high for exactly one cycle per search, and exactly one of `hit`, `free`, `full` is then set. These flags, `slot_index` and the attribute outputs hold their values until the next accepted start.
- R9: `start` is accepted only while `busy` and `done` are both low. A start during a search changes neither its key, its hashes nor its result.
- R10: On a hit, `ent_unicast` is the inverse of word 0 bit 24, `ent_static` is word 2 bit 14, `ent_trunk` is word 2 bit 30, `ent_port` is word 2 bits [29:20], and `ent_age` is word 2 bits [18:17]. On free or full, all of these outputs are zero.
- R11: If a search examines n candidates, `done` rises 2n clock edges after the edge that samples `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a search; sampled while idle |
| bkt_hash | input | 24 | Bucket hashes: block 0 in [11:0], block 1 in [23:12] |
| key_mac | input | 48 | MAC address to look up |
| key_fid | input | 12 | Filtering ID to look up |
| mem_rd | output | 1 | Entry memory read strobe |
| mem_addr | output | 14 | Entry memory read address |
| mem_rdata | input | 96 | Entry read data one cycle after `mem_rd`: word 0 in [31:0], word 1 in [63:32], word 2 in [95:64] |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| hit | output | 1 | Result: key found |
| free | output | 1 | Result: empty slot found |
| full | output | 1 | Result: no usable slot among eight |
| slot_index | output | 14 | Table index of the chosen slot |
| ent_unicast | output | 1 | Hit entry is unicast |
| ent_static | output | 1 | Hit entry is static |
| ent_trunk | output | 1 | Hit entry points to a trunk |
| ent_port | output | 10 | Hit entry port field |
| ent_age | output | 2 | Hit entry age field |

## Verification
Two decisions can fall on the same entry in one compare cycle: the next-hop exclusion and the key match. The bench provokes this by filling slots with next-hop entries that carry the search key exactly. It judges the outcome by the address sequence, which must move on past those slots, and by the final outcome, which must be a later hit, a later free slot, or full. The second overlap is a new start arriving in the middle of a running search. Here the bench presents a second key that would hit, and it checks that the result, read count and latency all belong to the first request.

// File: rtl/l2ss_pkg.sv
package l2ss_pkg;
   localparam int WORD_W      = 32;
   localparam int ENTRY_WORDS = 3;
   localparam int ENTRY_W     = WORD_W * ENTRY_WORDS;
   localparam int MAC_W       = 48;
   localparam int FID_W       = 12;
   localparam int PORT_W      = 10;
   localparam int AGE_W       = 2;

   // bit positions inside word 2
   localparam int W2_VALID  = 31;
   localparam int W2_TRUNK  = 30;
   localparam int W2_PORT   = 20;
   localparam int W2_AGE    = 17;
   localparam int W2_STATIC = 14;
   localparam int W2_NHOP   = 12;
   // group bit of first MAC byte, inside word 0
   localparam int W0_GROUP  = 24;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_READ = 2'd1,
      ST_CMP  = 2'd2,
      ST_DONE = 2'd3
   } srch_state_t;

   typedef enum logic [1:0] {
      VD_SKIP = 2'd0,
      VD_HIT  = 2'd1,
      VD_FREE = 2'd2
   } verdict_t;

   typedef struct packed {
      logic              unicast;
      logic              is_static;
      logic              trunk;
      logic [PORT_W-1:0] port;
      logic [AGE_W-1:0]  age;
   } ent_attr_t;
endpackage

// File: rtl/l2ss_slot_addr.sv
module l2ss_slot_addr #(
   parameter int HASH_W     = 12,
   parameter int BKT_SLOTS  = 4,
   parameter int NUM_HALVES = 2,
   localparam int POS_W     = $clog2(BKT_SLOTS),
   localparam int SLOT_W    = $clog2(BKT_SLOTS * NUM_HALVES),
   localparam int IDX_W     = HASH_W + POS_W
) (
   input  logic [NUM_HALVES*HASH_W-1:0] hashes,
   input  logic [SLOT_W-1:0]            slot,
   output logic [IDX_W-1:0]             idx
);
   logic [HASH_W-1:0] h_arr [NUM_HALVES];

   for (genvar g = 0; g < NUM_HALVES; g++) begin : g_split
      assign h_arr[g] = hashes[g*HASH_W +: HASH_W];
   end

   if (NUM_HALVES == 1) begin : g_single
      assign idx = {h_arr[0], slot[POS_W-1:0]};
   end else begin : g_multi
      logic [SLOT_W-POS_W-1:0] half;
      assign half = slot[SLOT_W-1:POS_W];
      assign idx  = {h_arr[half], slot[POS_W-1:0]};
   end
endmodule

// File: rtl/l2ss_entry_eval.sv
module l2ss_entry_eval
   import l2ss_pkg::*;
(
   input  logic [ENTRY_W-1:0] rdata,
   input  logic [MAC_W-1:0]   key_mac,
   input  logic [FID_W-1:0]   key_fid,
   output verdict_t           verdict,
   output ent_attr_t          attr
);
   logic [WORD_W-1:0] w [ENTRY_WORDS];

   for (genvar i = 0; i < ENTRY_WORDS; i++) begin : g_words
      assign w[i] = rdata[i*WORD_W +: WORD_W];
   end

   logic [MAC_W-1:0] ent_mac;
   logic [FID_W-1:0] ent_fid;
   logic             ent_valid;
   logic             ent_nhop;
   logic             key_eq;

   assign ent_mac   = {w[0], w[1][WORD_W-1 -: (MAC_W-WORD_W)]};
   assign ent_fid   = w[1][FID_W-1:0];
   assign ent_valid = w[2][W2_VALID];
   assign ent_nhop  = w[2][W2_NHOP];
   assign key_eq    = (ent_mac == key_mac) && (ent_fid == key_fid);

   always_comb begin
      if (!ent_valid)    verdict = VD_FREE;
      else if (ent_nhop) verdict = VD_SKIP;
      else if (key_eq)   verdict = VD_HIT;
      else               verdict = VD_SKIP;
   end

   assign attr.unicast   = ~w[0][W0_GROUP];
   assign attr.is_static = w[2][W2_STATIC];
   assign attr.trunk     = w[2][W2_TRUNK];
   assign attr.port      = w[2][W2_PORT +: PORT_W];
   assign attr.age       = w[2][W2_AGE +: AGE_W];
endmodule

// File: rtl/l2ss_ctrl.sv
module l2ss_ctrl
   import l2ss_pkg::*;
#(
   parameter int SLOT_TOTAL = 8,
   parameter int IDX_W      = 14,
   localparam int SLOT_W    = $clog2(SLOT_TOTAL)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  verdict_t          verdict,
   input  ent_attr_t         attr_in,
   input  logic [IDX_W-1:0]  cur_idx,
   output logic              accept,
   output logic [SLOT_W-1:0] slot,
   output logic              rd,
   output logic              busy,
   output logic              done,
   output logic              hit,
   output logic              free,
   output logic              full,
   output logic [IDX_W-1:0]  index,
   output ent_attr_t         attr_q
);
   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOT_TOTAL - 1);

   srch_state_t state;

   assign accept = (state == ST_IDLE) && start;
   assign rd     = (state == ST_READ);
   assign busy   = (state == ST_READ) || (state == ST_CMP);
   assign done   = (state == ST_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         slot   <= '0;
         hit    <= 1'b0;
         free   <= 1'b0;
         full   <= 1'b0;
         index  <= '0;
         attr_q <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (start) begin
                  state  <= ST_READ;
                  slot   <= '0;
                  hit    <= 1'b0;
                  free   <= 1'b0;
                  full   <= 1'b0;
                  index  <= '0;
                  attr_q <= '0;
               end
            end
            ST_READ: state <= ST_CMP;
            ST_CMP: begin
               case (verdict)
                  VD_HIT: begin
                     hit    <= 1'b1;
                     index  <= cur_idx;
                     attr_q <= attr_in;
                     state  <= ST_DONE;
                  end
                  VD_FREE: begin
                     free  <= 1'b1;
                     index <= cur_idx;
                     state <= ST_DONE;
                  end
                  default: begin
                     if (slot == LAST_SLOT) begin
                        full  <= 1'b1;
                        state <= ST_DONE;
                     end else begin
                        slot  <= slot + SLOT_W'(1);
                        state <= ST_READ;
                     end
                  end
               endcase
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/l2_slot_search.sv
module l2_slot_search
   import l2ss_pkg::*;
#(
   parameter int HASH_W     = 12,
   parameter int BKT_SLOTS  = 4,
   parameter int NUM_HALVES = 2,
   localparam int POS_W      = $clog2(BKT_SLOTS),
   localparam int SLOT_TOTAL = BKT_SLOTS * NUM_HALVES,
   localparam int SLOT_W     = $clog2(SLOT_TOTAL),
   localparam int IDX_W      = HASH_W + POS_W
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start,
   input  logic [NUM_HALVES*HASH_W-1:0] bkt_hash,
   input  logic [MAC_W-1:0]             key_mac,
   input  logic [FID_W-1:0]             key_fid,
   output logic                         mem_rd,
   output logic [IDX_W-1:0]             mem_addr,
   input  logic [ENTRY_W-1:0]           mem_rdata,
   output logic                         busy,
   output logic                         done,
   output logic                         hit,
   output logic                         free,
   output logic                         full,
   output logic [IDX_W-1:0]             slot_index,
   output logic                         ent_unicast,
   output logic                         ent_static,
   output logic                         ent_trunk,
   output logic [PORT_W-1:0]            ent_port,
   output logic [AGE_W-1:0]             ent_age
);
   initial begin : p_param_check
      if (BKT_SLOTS < 2 || (1 << POS_W) != BKT_SLOTS)
         $fatal(1, "BKT_SLOTS must be a power of two of at least 2");
      if (NUM_HALVES < 1 || (1 << $clog2(NUM_HALVES)) != NUM_HALVES)
         $fatal(1, "NUM_HALVES must be a power of two");
      if (HASH_W < 1)
         $fatal(1, "HASH_W must be positive");
   end

   logic [NUM_HALVES*HASH_W-1:0] hash_q;
   logic [MAC_W-1:0]             mac_q;
   logic [FID_W-1:0]             fid_q;
   logic                         accept;
   logic [SLOT_W-1:0]            slot;
   logic [IDX_W-1:0]             cur_idx;
   verdict_t                     verdict;
   ent_attr_t                    attr_rd;
   ent_attr_t                    attr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hash_q <= '0;
         mac_q  <= '0;
         fid_q  <= '0;
      end else if (accept) begin
         hash_q <= bkt_hash;
         mac_q  <= key_mac;
         fid_q  <= key_fid;
      end
   end

   l2ss_slot_addr #(
      .HASH_W     (HASH_W),
      .BKT_SLOTS  (BKT_SLOTS),
      .NUM_HALVES (NUM_HALVES)
   ) u_addr (
      .hashes (hash_q),
      .slot   (slot),
      .idx    (cur_idx)
   );

   l2ss_entry_eval u_eval (
      .rdata   (mem_rdata),
      .key_mac (mac_q),
      .key_fid (fid_q),
      .verdict (verdict),
      .attr    (attr_rd)
   );

   l2ss_ctrl #(
      .SLOT_TOTAL (SLOT_TOTAL),
      .IDX_W      (IDX_W)
   ) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .verdict (verdict),
      .attr_in (attr_rd),
      .cur_idx (cur_idx),
      .accept  (accept),
      .slot    (slot),
      .rd      (mem_rd),
      .busy    (busy),
      .done    (done),
      .hit     (hit),
      .free    (free),
      .full    (full),
      .index   (slot_index),
      .attr_q  (attr_q)
   );

   assign mem_addr    = cur_idx;
   assign ent_unicast = attr_q.unicast;
   assign ent_static  = attr_q.is_static;
   assign ent_trunk   = attr_q.trunk;
   assign ent_port    = attr_q.port;
   assign ent_age     = attr_q.age;
endmodule

// File: rtl/l2ss_checker.sv
module l2ss_checker #(
   parameter int IDX_W      = 14,
   parameter int SLOT_TOTAL = 8,
   parameter int PORT_W     = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              mem_rd,
   input logic              busy,
   input logic              done,
   input logic              hit,
   input logic              free,
   input logic              full,
   input logic [IDX_W-1:0]  slot_index,
   input logic              ent_unicast,
   input logic              ent_static,
   input logic              ent_trunk,
   input logic [PORT_W-1:0] ent_port,
   input logic [1:0]        ent_age
);
   logic [7:0] rd_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        rd_cnt <= '0;
      else if (start && !busy && !done)  rd_cnt <= '0;
      else if (mem_rd)                   rd_cnt <= rd_cnt + 8'd1;
   end

   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r8_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($countones({hit, free, full}) == 1));

   a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> $stable({hit, free, full, slot_index, ent_port}));

   a_r2_read_gap: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> !mem_rd);

   a_r9_read_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> busy);

   a_r7_full_eight_reads: assert property (@(posedge clk) disable iff (!rst_n)
      (done && full) |-> (rd_cnt == 8'(SLOT_TOTAL)));

   a_r7_full_index_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (done && full) |-> (slot_index == '0));

   a_r10_attr_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !hit) |->
         ({ent_unicast, ent_static, ent_trunk, ent_port, ent_age} == '0));
endmodule

bind l2_slot_search l2ss_checker #(
   .IDX_W      (IDX_W),
   .SLOT_TOTAL (SLOT_TOTAL),
   .PORT_W     (l2ss_pkg::PORT_W)
) u_l2ss_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .start       (start),
   .mem_rd      (mem_rd),
   .busy        (busy),
   .done        (done),
   .hit         (hit),
   .free        (free),
   .full        (full),
   .slot_index  (slot_index),
   .ent_unicast (ent_unicast),
   .ent_static  (ent_static),
   .ent_trunk   (ent_trunk),
   .ent_port    (ent_port),
   .ent_age     (ent_age)
);

// File: tb/l2_slot_search_bench.sv
`timescale 1ns/1ps
module l2_slot_search_bench;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [23:0]  bkt_hash = '0;
   logic [47:0]  key_mac = '0;
   logic [11:0]  key_fid = '0;
   logic         mem_rd;
   logic [13:0]  mem_addr;
   logic [95:0]  mem_rdata = '0;
   logic         busy, done, hit, free, full;
   logic [13:0]  slot_index;
   logic         ent_unicast, ent_static, ent_trunk;
   logic [9:0]   ent_port;
   logic [1:0]   ent_age;

   always #2.5 clk = ~clk;

   l2_slot_search u_l2_slot_search (
      .clk(clk), .rst_n(rst_n), .start(start), .bkt_hash(bkt_hash),
      .key_mac(key_mac), .key_fid(key_fid), .mem_rd(mem_rd),
      .mem_addr(mem_addr), .mem_rdata(mem_rdata), .busy(busy), .done(done),
      .hit(hit), .free(free), .full(full), .slot_index(slot_index),
      .ent_unicast(ent_unicast), .ent_static(ent_static),
      .ent_trunk(ent_trunk), .ent_port(ent_port), .ent_age(ent_age));

   // entry memory model, one cycle read latency, absent entries read as zero
   logic [95:0] mem [int];
   always @(posedge clk)
      if (mem_rd) mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 96'h0;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [13:0] slot_addr(input logic [11:0] a, input logic [11:0] b,
                                             input int k);
      return (k < 4) ? {a, 2'(k)} : {b, 2'(k - 4)};
   endfunction

   function automatic logic [95:0] mk(input logic [47:0] mac, input logic [11:0] fid,
                                      input logic [31:0] w2);
      return {w2, mac[15:0], 4'h0, fid, mac[47:16]};
   endfunction

   function automatic logic [9:0] port_of(input int k);
      return 10'(256 + k * 37);
   endfunction

   function automatic logic [31:0] attr_w2(input int k);
      return 32'h8000_0000 | (32'(k & 1) << 30) | (32'(port_of(k)) << 20)
           | (32'((k >> 1) & 3) << 17) | (32'((k >> 1) & 1) << 14);
   endfunction

   // read address monitor (R2)
   logic [11:0] cur_h0 = '0, cur_h1 = '0;
   int rd_n = 0;
   always @(negedge clk) begin
      if (rst_n && mem_rd) begin
         chk(mem_addr == slot_addr(cur_h0, cur_h1, rd_n), "R2", "read address",
             mem_addr, slot_addr(cur_h0, cur_h1, rd_n));
         rd_n++;
      end
   end

   // global watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc == 100000) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 100000);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   // slot codes: 0 empty-with-key, 1 match, 2 next-hop with key, 3 other key
   typedef struct packed {
      logic [15:0] pat;
      logic        mc;
      logic [11:0] h0;
      logic [11:0] h1;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{16'h0000, 1'b0, 12'h001, 12'h801},
      '{16'h0001, 1'b0, 12'h0FF, 12'h8FF},
      '{16'h001B, 1'b0, 12'h7FF, 12'hFFF},
      '{16'h01FF, 1'b0, 12'h000, 12'h800},
      '{16'h2AAA, 1'b0, 12'h123, 12'h923},
      '{16'hFFFF, 1'b0, 12'hABC, 12'h2BC},
      '{16'hAAAA, 1'b0, 12'hFFF, 12'h7FF},
      '{16'hF7BB, 1'b1, 12'h456, 12'hC56},
      '{16'h0012, 1'b0, 12'h010, 12'h810},
      '{16'h007F, 1'b1, 12'h3A5, 12'hBA5}
   };

   task automatic fill(input logic [15:0] pat, input logic [11:0] a, input logic [11:0] b,
                       input logic [47:0] mac, input logic [11:0] fid);
      mem.delete();
      for (int k = 0; k < 8; k++) begin
         logic [95:0] e;
         case (pat[2*k +: 2])
            2'd0:    e = mk(mac, fid, 32'h0000_1000);
            2'd1:    e = mk(mac, fid, attr_w2(k));
            2'd2:    e = mk(mac, fid, attr_w2(k) | 32'h0000_1000);
            default: e = (k % 2 == 0) ? mk(mac, fid ^ 12'h001, attr_w2(k))
                                      : mk(mac ^ 48'h1, fid, attr_w2(k));
         endcase
         mem[int'(slot_addr(a, b, k))] = e;
      end
   endtask

   task automatic do_search(input logic [11:0] a, input logic [11:0] b,
                            input logic [47:0] mac, input logic [11:0] fid,
                            output int lat);
      @(negedge clk);
      bkt_hash = {b, a};
      key_mac  = mac;
      key_fid  = fid;
      cur_h0   = a;
      cur_h1   = b;
      rd_n     = 0;
      start    = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      while (!done && lat < 200) begin
         @(negedge clk);
         lat++;
      end
   endtask

   initial begin
      int lat;
      // R1: reset values
      repeat (3) @(negedge clk);
      chk({busy, done, hit, free, full, mem_rd} == 6'b0, "R1", "flags in reset",
          {busy, done, hit, free, full, mem_rd}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({slot_index, ent_unicast, ent_static, ent_trunk, ent_port, ent_age} == '0,
          "R1", "outputs after reset",
          {slot_index, ent_unicast, ent_static, ent_trunk, ent_port, ent_age}, 0);
      chk({busy, done, hit, free, full, mem_rd} == 6'b0, "R1", "flags after reset",
          {busy, done, hit, free, full, mem_rd}, 0);

      for (int i = 0; i < NV; i++) begin
         logic [47:0] mac;
         logic [11:0] fid;
         int          kind, slot_k, nrd;
         logic [13:0] exp_idx;
         logic [2:0]  flags;
         mac = VECS[i].mc ? 48'h0B11_2233_4455 : 48'h0A11_2233_4455;
         fid = 12'h5A0 + 12'(i);
         fill(VECS[i].pat, VECS[i].h0, VECS[i].h1, mac, fid);
         kind = 3; slot_k = 8;
         for (int k = 0; k < 8; k++) begin
            if (kind == 3 && VECS[i].pat[2*k +: 2] == 2'd0) begin kind = 2; slot_k = k; end
            if (kind == 3 && VECS[i].pat[2*k +: 2] == 2'd1) begin kind = 1; slot_k = k; end
         end
         nrd     = (kind == 3) ? 8 : slot_k + 1;
         exp_idx = (kind == 3) ? 14'h0 : slot_addr(VECS[i].h0, VECS[i].h1, slot_k);
         do_search(VECS[i].h0, VECS[i].h1, mac, fid, lat);
         flags = (kind == 1) ? 3'b100 : (kind == 2) ? 3'b010 : 3'b001;
         if (kind == 1)
            chk({hit, free, full} == flags, "R3", "outcome hit", {hit, free, full}, flags);
         else if (kind == 2)
            chk({hit, free, full} == flags, "R4", "outcome free", {hit, free, full}, flags);
         else
            chk({hit, free, full} == flags, "R7", "outcome full", {hit, free, full}, flags);
         chk(slot_index == exp_idx, "R3 R4 R7", "slot_index", slot_index, exp_idx);
         chk(rd_n == nrd, "R5 R6", "reads before stop", rd_n, nrd);
         chk(lat == 2 * nrd, "R11", "latency", lat, 2 * nrd);
         if (kind == 1)
            chk({ent_unicast, ent_static, ent_trunk, ent_port, ent_age} ==
                {~VECS[i].mc, 1'((slot_k >> 1) & 1), 1'(slot_k & 1), port_of(slot_k),
                 2'((slot_k >> 1) & 3)},
                "R10", "hit attributes",
                {ent_unicast, ent_static, ent_trunk, ent_port, ent_age},
                {~VECS[i].mc, 1'((slot_k >> 1) & 1), 1'(slot_k & 1), port_of(slot_k),
                 2'((slot_k >> 1) & 3)});
         else
            chk({ent_unicast, ent_static, ent_trunk, ent_port, ent_age} == '0,
                "R10", "attributes zero", {ent_unicast, ent_static, ent_trunk, ent_port, ent_age}, 0);
         // R8: pulse ends, result holds while inputs move
         key_mac = 48'h0;
         key_fid = 12'h0;
         bkt_hash = 24'h0;
         @(negedge clk);
         chk(!done, "R8", "done single cycle", done, 0);
         repeat (2) @(negedge clk);
         chk({hit, free, full} == flags && slot_index == exp_idx, "R8", "result held",
             {hit, free, full, slot_index}, {flags, exp_idx});
      end

      // R9: start during a running search is ignored
      begin
         logic [47:0] mac1, mac2;
         logic [11:0] fid1;
         mac1 = 48'h0A55_6677_8899;
         fid1 = 12'h321;
         fill(16'hFFFF, 12'h111, 12'h911, mac1, fid1);
         mac2 = mac1 ^ 48'h1;   // equals the key of the odd-slot entries
         @(negedge clk);
         bkt_hash = {12'h911, 12'h111};
         key_mac = mac1; key_fid = fid1;
         cur_h0 = 12'h111; cur_h1 = 12'h911; rd_n = 0;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         lat = 0;
         repeat (3) begin @(negedge clk); lat++; end
         key_mac = mac2;
         start = 1'b1;
         @(negedge clk); lat++;
         start = 1'b0;
         while (!done && lat < 200) begin @(negedge clk); lat++; end
         chk({hit, free, full} == 3'b001, "R9", "outcome of first request",
             {hit, free, full}, 3'b001);
         chk(lat == 16, "R9", "latency of first request", lat, 16);
         chk(rd_n == 8, "R9", "reads of first request", rd_n, 8);
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule